// File: doc/BRIEF.md
# Flow-Through Burst Memory with Dual Address Strobes

This block is a clocked single-port word memory. Address, control and write data are captured on the rising clock edge. Read data leaves the block without an output register: once an edge has set the address in effect, the stored word appears on the read port combinationally in the same cycle. One presented address serves four data cycles. The first cycle uses the captured address. Each later edge with the advance input low steps a two-bit burst counter, which gives a 2-1-1-1 pattern. Two address strobes can start an access: one for the processor side and one for the cache-controller side.

Writes are made per byte lane. The write-all input writes the whole word. The byte-write input writes only the lanes whose select is low. The sleep and output-enable inputs act at once on the read port, without waiting for a clock edge. The memory keeps its contents through sleep. The default depth is 1024 words (`ADDR_W` = 10). With `ADDR_W` = 15 the memory holds 32768 words of 32 bits.

Top module: `fthru_burst_ram`

## Requirements
- R1: The memory holds 2**ADDR_W words of LANES*LANE_W bits, and each word has its own address. A write to one address leaves every other address unchanged, including the lowest and highest addresses.
- R2: Inputs are sampled only on the rising edge of `clk`. After each edge, `rdata` shows the stored word at the address in effect, in the same cycle, with no extra register stage.
- R3: An accepted strobe loads `addr` and clears the burst counter to 0. Advance (`step_n` low) is ignored on a load edge. On every other edge of an active access, `step_n` low increments the counter modulo 4, and `step_n` high holds the counter.
- R4: When `order_lin`=1 at the load edge, the low two address bits of the burst are (start + n) mod 4 for counter value n; a start of 1 gives 1,2,3,0. The upper address bits do not change during the burst.
- R5: When `order_lin`=0 at the load edge, the low two address bits are start XOR n; a start of 1 gives 1,0,3,2. The order is held until the next load.
- R6: The chip is selected when `chip_en_n`=0, `sel_hi`=1 and `sel_lo_n`=0. `strb_cpu_n` low is ignored while the chip is deselected, and the access in progress continues. `strb_ctl_n` low always loads. If it loads while the chip is deselected, the access ends: `rdata` reads 0 and writes are blocked until the next accepted strobe.
- R7: If `wr_all_n`=0, all lanes are written. Otherwise, if `wr_byte_n`=0, lane i (bits 8i+7:8i) is written only when `lane_sel_n[i]`=0. If neither input is low, the cycle is a read.
- R8: A write sampled at an edge takes the `wdata` of that edge and applies it to the address in effect after that edge. The word is committed at the next edge. During the write cycle `rdata` is 0.
- R9: `out_en_n`=1 forces `rdata` to 0 at once, without waiting for a clock edge.
- R10: `sleep`=1 forces `rdata` to 0 at once. While it is high, no write commits, strobes and advance are ignored, the address in effect is held, and the stored data is kept.
- R11: After a synchronous reset (`rst`=1 on an edge), no access is active, no write is pending, and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Start address, captured on a load |
| chip_en_n | input | 1 | Chip enable, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output enable, active low, acts without a clock |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Byte write qualifier, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| sleep | input | 1 | Sleep, active high, acts without a clock |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, flow-through |

## Verification
The assertions assume that every input has a known value at each sampled edge. They also assume that `sleep` and `out_en_n` change only away from the clock edge, so that the checks which apply without a clock see a settled value. The bench drives every input a short time after a rising edge and compares the results before the next edge. It moves `sleep` and `out_en_n` in the middle of a cycle, and it always holds the strobes high while reset is asserted.

// File: rtl/fb_pkg.sv
package fb_pkg;

  // Low two address bits for counter value cnt of a burst that starts at start.
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] cnt,
                                          input logic       lin);
    return lin ? (start + cnt) : (start ^ cnt);
  endfunction

  // Which lanes to write. Write-all takes priority over the byte-write qualifier.
  function automatic logic [3:0] lane_mask4(input logic       all_n,
                                            input logic       byte_n,
                                            input logic [3:0] sel_n);
    if (!all_n)       return 4'hF;
    else if (!byte_n) return ~sel_n;
    else              return 4'h0;
  endfunction

endpackage

// File: rtl/fb_burst_ctr.sv
module fb_burst_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              ld,
  input  logic              sel_now,
  input  logic              step_n,
  input  logic              order_lin,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              act_q,
  output logic              act_d
);
  import fb_pkg::*;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              lin_q, lin_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    lin_d  = lin_q;
    act_d  = act_q;
    if (!sleep) begin
      if (ld) begin
        base_d = addr;
        cnt_d  = 2'd0;
        lin_d  = order_lin;
        act_d  = sel_now;
      end else if (!step_n && act_q) begin
        cnt_d = cnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      lin_q  <= 1'b1;
      act_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      lin_q  <= lin_d;
      act_q  <= act_d;
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], cnt_q, lin_q)};

endmodule

// File: rtl/fb_wr_ctl.sv
module fb_wr_ctl #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep,
  input  logic             act_d,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic [DW-1:0]    wdata,
  output logic [LANES-1:0] wmask_q,
  output logic [DW-1:0]    wdata_q
);
  logic [LANES-1:0] mask_d;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign mask_d[i] = !wr_all_n || (!wr_byte_n && !lane_sel_n[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wmask_q <= '0;
    end else begin
      wmask_q <= (act_d && !sleep) ? mask_d : '0;
    end
  end

  always_ff @(posedge clk) begin
    wdata_q <= wdata;
  end

endmodule

// File: rtl/fb_array.sv
module fb_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata
);
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (we[i]) mem[waddr] <= wdata[i*LANE_W +: LANE_W];
      end
      assign rdata[i*LANE_W +: LANE_W] = mem[raddr];
    end
  endgenerate

endmodule

// File: rtl/fthru_burst_ram.sv
module fthru_burst_ram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chip_en_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic              out_en_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              step_n,
  input  logic              order_lin,
  input  logic              sleep,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic              sel_now;
  logic              ld;
  logic [ADDR_W-1:0] cur_addr;
  logic              act_q, act_d;
  logic [LANES-1:0]  wmask_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] arr_rdata;
  logic              blank;

  assign sel_now = !chip_en_n && sel_hi && !sel_lo_n;
  assign ld      = !strb_ctl_n || (!strb_cpu_n && sel_now);

  fb_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .sleep    (sleep),
    .ld       (ld),
    .sel_now  (sel_now),
    .step_n   (step_n),
    .order_lin(order_lin),
    .addr     (addr),
    .cur_addr (cur_addr),
    .act_q    (act_q),
    .act_d    (act_d)
  );

  fb_wr_ctl #(.LANES(LANES), .LANE_W(LANE_W)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .sleep     (sleep),
    .act_d     (act_d),
    .wr_all_n  (wr_all_n),
    .wr_byte_n (wr_byte_n),
    .lane_sel_n(lane_sel_n),
    .wdata     (wdata),
    .wmask_q   (wmask_q),
    .wdata_q   (wdata_q)
  );

  fb_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk  (clk),
    .we   (sleep ? '0 : wmask_q),
    .waddr(cur_addr),
    .wdata(wdata_q),
    .raddr(cur_addr),
    .rdata(arr_rdata)
  );

  assign blank = sleep || out_en_n || !act_q || (|wmask_q);
  assign rdata = blank ? '0 : arr_rdata;

endmodule

// File: rtl/fb_chk.sv
module fb_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep,
  input logic              out_en_n,
  input logic              strb_cpu_n,
  input logic              strb_ctl_n,
  input logic              step_n,
  input logic              sel_now,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [LANES-1:0]  wmask_q,
  input logic [DATA_W-1:0] rdata
);

  AST_OE_BLANK: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> rdata == '0); // R9

  AST_SLEEP_BLANK: assert property (@(posedge clk) disable iff (rst)
    sleep |-> rdata == '0); // R10

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    sleep |=> $stable(cur_addr)); // R10

  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sleep && strb_cpu_n && strb_ctl_n && step_n) |=> $stable(cur_addr)); // R3

  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !strb_ctl_n) |=> cur_addr == $past(addr)); // R6

  AST_CPU_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!sleep && strb_ctl_n && !strb_cpu_n && !sel_now && step_n) |=> $stable(cur_addr)); // R6

  AST_WR_BLANK: assert property (@(posedge clk) disable iff (rst)
    (|wmask_q) |-> rdata == '0); // R8

endmodule

bind fthru_burst_ram fb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sleep     (sleep),
  .out_en_n  (out_en_n),
  .strb_cpu_n(strb_cpu_n),
  .strb_ctl_n(strb_ctl_n),
  .step_n    (step_n),
  .sel_now   (sel_now),
  .addr      (addr),
  .cur_addr  (cur_addr),
  .wmask_q   (wmask_q),
  .rdata     (rdata)
);

// File: tb/fthru_burst_ram_test.sv
module fthru_burst_ram_test;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          chip_en_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
  logic          out_en_n = 1'b0, wr_all_n = 1'b1, wr_byte_n = 1'b1;
  logic [3:0]    lane_sel_n = 4'hF;
  logic          strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, step_n = 1'b1;
  logic          order_lin = 1'b1, sleep = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [31:0] ref_mem [DEPTH];
  int          m_base = 0, m_cnt = 0;
  bit          m_lin = 1, m_act = 0;
  logic [3:0]  m_pmask = '0;
  logic [31:0] m_pdata = '0;

  fthru_burst_ram #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .addr(addr), .chip_en_n(chip_en_n), .sel_hi(sel_hi),
    .sel_lo_n(sel_lo_n), .out_en_n(out_en_n), .wr_all_n(wr_all_n),
    .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n), .strb_cpu_n(strb_cpu_n),
    .strb_ctl_n(strb_ctl_n), .step_n(step_n), .order_lin(order_lin),
    .sleep(sleep), .wdata(wdata), .rdata(rdata)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] fillv(int a);
    return 32'hA500_0000 ^ (32'(a) * 32'h0001_0003);
  endfunction

  function automatic int m_cur();
    int lo;
    lo = m_lin ? ((m_base + m_cnt) & 3) : ((m_base & 3) ^ m_cnt);
    return (m_base & ~3) | lo;
  endfunction

  function automatic logic [31:0] m_exp();
    if (sleep || out_en_n || !m_act || m_pmask != 0) return '0;
    return ref_mem[m_cur()];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // model update for one rising edge, from the inputs that were stable before it
  task automatic model_edge();
    bit sel, ld;
    int cur;
    if (rst) begin
      m_act = 0; m_pmask = '0; m_cnt = 0; m_base = 0; m_lin = 1;
      return;
    end
    if (m_pmask != 0 && !sleep) begin
      cur = m_cur();
      for (int i = 0; i < 4; i++)
        if (m_pmask[i]) ref_mem[cur][i*8 +: 8] = m_pdata[i*8 +: 8];
    end
    m_pdata = wdata;
    if (sleep) begin
      m_pmask = '0;
    end else begin
      sel = !chip_en_n && sel_hi && !sel_lo_n;
      ld  = !strb_ctl_n || (!strb_cpu_n && sel);
      if (ld) begin
        m_base = int'(addr); m_cnt = 0; m_lin = order_lin; m_act = sel;
      end else if (!step_n && m_act) begin
        m_cnt = (m_cnt + 1) % 4;
      end
      if (!m_act)         m_pmask = '0;
      else if (!wr_all_n) m_pmask = 4'hF;
      else if (!wr_byte_n) m_pmask = ~lane_sel_n;
      else                m_pmask = '0;
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    #2;
    chk(tag, rdata, m_exp());
  endtask

  task automatic idle();
    strb_cpu_n = 1; strb_ctl_n = 1; step_n = 1; wr_all_n = 1; wr_byte_n = 1;
    lane_sel_n = 4'hF;
  endtask

  task automatic ctl_load(int a, bit lin);
    idle(); addr = AW'(a); order_lin = lin; strb_ctl_n = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (3) tick("R11");
    rst = 0;
    tick("R11");
    chk("R11", rdata, 32'h0);

    // fill the whole memory with linear burst writes (R1, R7, R8)
    for (int b = 0; b < DEPTH; b += 4) begin
      ctl_load(b, 1); wr_all_n = 0; step_n = 0; wdata = fillv(b);
      tick("R8");
      for (int k = 1; k < 4; k++) begin
        idle(); wr_all_n = 0; step_n = 0; wdata = fillv(b + k);
        tick("R8");
      end
    end
    idle(); tick("R8");

    // R4 linear burst from 0x41
    ctl_load(32'h41, 1); step_n = 0; tick("R4"); chk("R4", rdata, fillv(32'h41));
    idle(); step_n = 0; tick("R4"); chk("R4", rdata, fillv(32'h42));
    tick("R4"); chk("R4", rdata, fillv(32'h43));
    tick("R4"); chk("R4", rdata, fillv(32'h40));
    // R2 flow-through: address change visible in the same cycle
    tick("R2"); chk("R2", rdata, fillv(32'h41));

    // R5 interleaved burst from 0x45
    ctl_load(32'h45, 0); tick("R5"); chk("R5", rdata, fillv(32'h45));
    idle(); step_n = 0; tick("R5"); chk("R5", rdata, fillv(32'h44));
    tick("R5"); chk("R5", rdata, fillv(32'h47));
    tick("R5"); chk("R5", rdata, fillv(32'h46));
    // R3 hold with step_n high
    idle(); tick("R3"); chk("R3", rdata, fillv(32'h46));
    tick("R3"); chk("R3", rdata, fillv(32'h46));

    // R6 processor strobe ignored while deselected
    sel_hi = 0; strb_cpu_n = 0; addr = AW'(32'h47);
    tick("R6"); chk("R6", rdata, fillv(32'h46));
    // R6 controller strobe while deselected ends access, write blocked
    ctl_load(32'h44, 1); wr_all_n = 0; wdata = 32'h0;
    tick("R6"); chk("R6", rdata, 32'h0);
    idle(); tick("R6"); chk("R6", rdata, 32'h0);
    sel_hi = 1; ctl_load(32'h44, 1);
    tick("R6"); chk("R6", rdata, fillv(32'h44));
    idle(); strb_cpu_n = 0; addr = AW'(32'h43);
    tick("R6"); chk("R6", rdata, fillv(32'h43));

    // R7/R8 byte write lanes 0 and 2 at 0x42
    ctl_load(32'h42, 1); wr_byte_n = 0; lane_sel_n = 4'b1010; wdata = 32'hFFFF_FFFF;
    tick("R8"); chk("R8", rdata, 32'h0);
    idle(); tick("R7"); chk("R7", rdata, fillv(32'h42) | 32'h00FF_00FF);
    // R7 write-all overrides byte selects
    ctl_load(32'h48, 1); wr_all_n = 0; wr_byte_n = 0; lane_sel_n = 4'hF; wdata = 32'h1234_5678;
    tick("R7");
    idle(); tick("R7"); chk("R7", rdata, 32'h1234_5678);
    // R7 no write enable: read only
    ctl_load(32'h49, 1); wdata = 32'h0; tick("R7"); chk("R7", rdata, fillv(32'h49));

    // R1 lowest and highest address
    ctl_load(0, 1); wr_all_n = 0; wdata = 32'h0BAD_0000; tick("R1");
    ctl_load(DEPTH - 1, 1); wr_all_n = 0; wdata = 32'h0BAD_FFFF; tick("R1");
    ctl_load(0, 1); tick("R1"); chk("R1", rdata, 32'h0BAD_0000);
    ctl_load(DEPTH - 1, 1); tick("R1"); chk("R1", rdata, 32'h0BAD_FFFF);
    ctl_load(1, 1); tick("R1"); chk("R1", rdata, fillv(1));

    // R9 output enable acts without a clock
    idle(); #1; out_en_n = 1; #1; chk("R9", rdata, 32'h0);
    out_en_n = 0; #1; chk("R9", rdata, fillv(1));

    // R10 sleep: blank, hold, no write
    sleep = 1; #1; chk("R10", rdata, 32'h0);
    ctl_load(32'h40, 1); wr_all_n = 0; wdata = 32'h0;
    tick("R10");
    idle(); step_n = 0; tick("R10");
    idle(); sleep = 0; #1; chk("R10", rdata, fillv(1));
    ctl_load(32'h40, 1); tick("R10"); chk("R10", rdata, fillv(32'h40));

    // mixed stimulus, model compared every cycle (R2)
    for (int n = 0; n < 3000; n++) begin
      idle();
      addr       = AW'($urandom);
      strb_ctl_n = ($urandom % 8) != 0;
      strb_cpu_n = ($urandom % 8) != 0;
      sel_hi     = ($urandom % 16) != 0;
      chip_en_n  = ($urandom % 32) == 0;
      step_n     = $urandom % 2;
      order_lin  = $urandom % 2;
      wr_all_n   = ($urandom % 6) != 0;
      wr_byte_n  = ($urandom % 4) != 0;
      lane_sel_n = 4'($urandom);
      wdata      = $urandom;
      out_en_n   = ($urandom % 16) == 0;
      sleep      = ($urandom % 32) == 0;
      tick("R2");
    end
    out_en_n = 0; sleep = 0; chip_en_n = 0; sel_hi = 1;

    // reset mid-operation returns to idle (R11)
    rst = 1; idle(); tick("R11"); rst = 0; tick("R11"); chk("R11", rdata, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule